// File: doc/BRIEF.md
# Serial Address and Mode Command Decoder

This block sits in front of a sequential-access video memory array. It collects two serial words that share one address clock. One word is an 8-bit row address. The other is an 8-bit word that holds a 6-bit column and two mode bits. Both words arrive least significant bit first. All pins are treated as asynchronous and are sampled in one system clock domain. A falling edge on the row strobe latches both words and decodes the two mode bits into one of four array operations. The block then gives the array a row, a column and a one-cycle command pulse.

The two read operations (into output latch A or into output latch B) fire on the strobe's falling edge. The write operation (from the input latch) is armed on the falling edge and fires on the following rising edge. Refresh fires on the falling edge. For refresh, the block drives the row from an internal 8-bit counter that then advances, and the row received on the serial line is not used. A strobe that falls before eight address clocks have arrived still latches whatever the shift registers hold at that moment, and it also raises an error flag.

Every output is a registered control level or a pulse. No output has valid/ready flow control, and the consumer cannot apply back-pressure. Each command pulse must be taken in the cycle it appears.

Top module: `serial_cmd_decoder`

## Requirements
- R1: After reset all command pulses are 0, `row_addr` and `col_addr` are 0, `short_err` is 0 and the refresh counter is 0.
- R2: Both serial lines are sampled on each rising edge of `addr_clk`, and the first bit received is bit 0. After a strobe fall, `row_addr` equals the received row word (except in refresh), and `col_addr` equals bits [5:0] of the received code word.
- R3: Mode code {bit7,bit6} = 00 produces exactly one `cmd_rd_a` pulse, one clock long, on the strobe fall.
- R4: Mode code 01 produces exactly one `cmd_rd_b` pulse, one clock long, on the strobe fall.
- R5: Mode code 10 produces no pulse on the strobe fall. It produces one `cmd_wr` pulse, one clock long, on the next strobe rise, and `row_addr` and `col_addr` do not change at that pulse.
- R6: Mode code 11 produces one `cmd_ref` pulse on the strobe fall. The received row is ignored and `row_addr` shows the refresh counter. The counter then increments and wraps from 255 to 0.
- R7: A strobe fall after fewer than eight `addr_clk` rises since the previous fall sets `short_err` to 1 and still latches the current shift contents. A fall after eight or more rises sets it to 0. `short_err` holds its value until the next fall.
- R8: If more than eight bits arrive before a fall, only the last eight received on each line are kept.
- R9: No two command pulses are ever high together, and no command pulse lasts longer than one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_clk | input | 1 | Serial address clock (asynchronous) |
| row_sdi | input | 1 | Serial row-address line |
| code_sdi | input | 1 | Serial column/mode line |
| row_strobe | input | 1 | Row strobe; idle high |
| row_addr | output | 8 | Row for the current operation |
| col_addr | output | 6 | Column for the current operation |
| cmd_rd_a | output | 1 | Pulse: read array into latch A |
| cmd_rd_b | output | 1 | Pulse: read array into latch B |
| cmd_wr | output | 1 | Pulse: write input latch into array |
| cmd_ref | output | 1 | Pulse: refresh row `row_addr` |
| short_err | output | 1 | Last fall came after fewer than 8 address clocks |

## Verification
Each pin passes through a two-flop synchroniser and an edge register, and the outputs are registered after that. A result therefore appears after the third rising `clk` edge that follows a pin change. A shifted bit enters its register at that same third edge. The bench changes pins on falling `clk` edges and reads results on falling edges. It checks that the command pulse vector is zero at the second and fourth falling edges after a strobe change, and that it holds the expected code at the third. It holds every data bit stable for three clocks on each side of an `addr_clk` rise.

// File: rtl/scd_pkg.sv
package scd_pkg;
  typedef enum logic [1:0] {
    OP_RD_A = 2'b00,
    OP_RD_B = 2'b01,
    OP_WR   = 2'b10,
    OP_REF  = 2'b11
  } op_e;
endpackage

// File: rtl/scd_sync.sv
// Multi-bit synchroniser chain with a per-bit reset value.
module scd_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/scd_shift.sv
// LSB-first serial-in register: the first bit received ends at bit 0.
module scd_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sdi,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data <= '0;
    else if (shift_en) data <= {sdi, data[W-1:1]};
  end
endmodule

// File: rtl/scd_bitcnt.sv
// Saturating count of address clocks since the last strobe fall.
module scd_bitcnt #(
  parameter int FULL = 8,
  localparam int CW  = $clog2(FULL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic clr,
  output logic short_now
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (clr)                        cnt <= '0;
    else if (inc && cnt != CW'(FULL))    cnt <= cnt + 1'b1;
  end

  assign short_now = (cnt != CW'(FULL));
endmodule

// File: rtl/scd_issue.sv
// Latches address/mode at the strobe fall and issues command pulses.
module scd_issue
  import scd_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  localparam int CODE_W = COL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              rise,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [CODE_W-1:0] code_in,
  input  logic              short_in,
  output logic [ROW_W-1:0]  row_addr,
  output logic [COL_W-1:0]  col_addr,
  output logic              rd_a,
  output logic              rd_b,
  output logic              wr,
  output logic              ref_p,
  output logic              err
);
  logic [ROW_W-1:0] ref_cnt;
  logic             wr_pend;
  op_e              op;

  assign op = op_e'(code_in[CODE_W-1 -: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_addr <= '0;
      col_addr <= '0;
      ref_cnt  <= '0;
      wr_pend  <= 1'b0;
      err      <= 1'b0;
      rd_a     <= 1'b0;
      rd_b     <= 1'b0;
      wr       <= 1'b0;
      ref_p    <= 1'b0;
    end else begin
      rd_a  <= 1'b0;
      rd_b  <= 1'b0;
      wr    <= 1'b0;
      ref_p <= 1'b0;
      if (fall) begin
        col_addr <= code_in[COL_W-1:0];
        err      <= short_in;
        wr_pend  <= 1'b0;
        unique case (op)
          OP_RD_A: begin row_addr <= row_in; rd_a <= 1'b1; end
          OP_RD_B: begin row_addr <= row_in; rd_b <= 1'b1; end
          OP_WR:   begin row_addr <= row_in; wr_pend <= 1'b1; end
          OP_REF:  begin
            row_addr <= ref_cnt;
            ref_cnt  <= ref_cnt + 1'b1;
            ref_p    <= 1'b1;
          end
        endcase
      end else if (rise && wr_pend) begin
        wr      <= 1'b1;
        wr_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder #(
  parameter int ROW_W       = 8,
  parameter int COL_W       = 6,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W     = COL_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_clk,
  input  logic             row_sdi,
  input  logic             code_sdi,
  input  logic             row_strobe,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic             cmd_rd_a,
  output logic             cmd_rd_b,
  output logic             cmd_wr,
  output logic             cmd_ref,
  output logic             short_err
);
  // bit order in the synchroniser: {strobe, addr_clk, code, row}
  logic [3:0] s_q;
  logic       clk_prev, stb_prev;
  logic       clk_rise, stb_fall, stb_rise, short_now;
  logic [ROW_W-1:0]  row_sr;
  logic [CODE_W-1:0] code_sr;

  scd_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({row_strobe, addr_clk, code_sdi, row_sdi}),
    .q(s_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b0;
      stb_prev <= 1'b1;
    end else begin
      clk_prev <= s_q[2];
      stb_prev <= s_q[3];
    end
  end

  assign clk_rise = s_q[2] & ~clk_prev;
  assign stb_fall = ~s_q[3] & stb_prev;
  assign stb_rise = s_q[3] & ~stb_prev;

  scd_shift #(.W(ROW_W)) u_row_sr (
    .clk(clk), .rst_n(rst_n), .shift_en(clk_rise), .sdi(s_q[0]), .data(row_sr)
  );

  scd_shift #(.W(CODE_W)) u_code_sr (
    .clk(clk), .rst_n(rst_n), .shift_en(clk_rise), .sdi(s_q[1]), .data(code_sr)
  );

  scd_bitcnt #(.FULL(CODE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(clk_rise), .clr(stb_fall), .short_now(short_now)
  );

  scd_issue #(.ROW_W(ROW_W), .COL_W(COL_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .fall(stb_fall), .rise(stb_rise),
    .row_in(row_sr), .code_in(code_sr), .short_in(short_now),
    .row_addr(row_addr), .col_addr(col_addr),
    .rd_a(cmd_rd_a), .rd_b(cmd_rd_b), .wr(cmd_wr), .ref_p(cmd_ref),
    .err(short_err)
  );
endmodule

// File: rtl/scd_chk.sv
module scd_chk #(
  parameter int ROW_W = 8,
  parameter int COL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ROW_W-1:0] row_addr,
  input logic [COL_W-1:0] col_addr,
  input logic             cmd_rd_a,
  input logic             cmd_rd_b,
  input logic             cmd_wr,
  input logic             cmd_ref
);
  logic             seen_ref;
  logic [ROW_W-1:0] last_ref;
  logic             any_cmd;

  assign any_cmd = cmd_rd_a | cmd_rd_b | cmd_wr | cmd_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_ref <= 1'b0;
      last_ref <= '0;
    end else if (cmd_ref) begin
      seen_ref <= 1'b1;
      last_ref <= row_addr;
    end
  end

  // R9
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_rd_a, cmd_rd_b, cmd_wr, cmd_ref}));

  // R9
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |=> !any_cmd);

  // R6
  ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ref && seen_ref) |-> (row_addr == last_ref + 1'b1));

  // R5
  wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> ($stable(row_addr) && $stable(col_addr)));
endmodule

bind serial_cmd_decoder scd_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_addr(row_addr), .col_addr(col_addr),
  .cmd_rd_a(cmd_rd_a), .cmd_rd_b(cmd_rd_b), .cmd_wr(cmd_wr), .cmd_ref(cmd_ref)
);

// File: tb/sim_serial_cmd_decoder.sv
`timescale 1ns/1ps
module sim_serial_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_clk = 1'b0, row_sdi = 1'b0, code_sdi = 1'b0, row_strobe = 1'b1;
  logic [7:0] row_addr;
  logic [5:0] col_addr;
  logic cmd_rd_a, cmd_rd_b, cmd_wr, cmd_ref, short_err;

  int nchk = 0, nerr = 0;
  logic [7:0] m_row = '0, m_code = '0, m_ref = '0;
  int m_bits = 0;

  always #10 clk = ~clk;  // 50 MHz

  serial_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .addr_clk(addr_clk), .row_sdi(row_sdi),
    .code_sdi(code_sdi), .row_strobe(row_strobe), .row_addr(row_addr),
    .col_addr(col_addr), .cmd_rd_a(cmd_rd_a), .cmd_rd_b(cmd_rd_b),
    .cmd_wr(cmd_wr), .cmd_ref(cmd_ref), .short_err(short_err)
  );

  function automatic logic [3:0] pv();
    return {cmd_rd_a, cmd_rd_b, cmd_wr, cmd_ref};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2 R8: shift n bits, bit k of each word goes out k-th (mod 8)
  task automatic send(input logic [7:0] r, input logic [7:0] c, input int n);
    for (int k = 0; k < n; k++) begin
      row_sdi  = r[k % 8];
      code_sdi = c[k % 8];
      m_row  = {r[k % 8], m_row[7:1]};
      m_code = {c[k % 8], m_code[7:1]};
      m_bits++;
      tick(3); addr_clk = 1'b1;
      tick(3); addr_clk = 1'b0;
      tick(1);
    end
  endtask

  task automatic xact();
    logic [1:0] md;
    logic [3:0] ef, er;
    logic [7:0] erow;
    string tag;
    md = m_code[7:6];
    case (md)
      2'b00: begin ef = 4'b1000; er = 4'b0000; tag = "R3"; erow = m_row; end
      2'b01: begin ef = 4'b0100; er = 4'b0000; tag = "R4"; erow = m_row; end
      2'b10: begin ef = 4'b0000; er = 4'b0010; tag = "R5"; erow = m_row; end
      default: begin ef = 4'b0001; er = 4'b0000; tag = "R6"; erow = m_ref; m_ref++; end
    endcase
    row_strobe = 1'b0;
    tick(2); chk("R9 early", pv(), 4'b0000);
    tick(1); chk(tag, pv(), ef);
    chk("R2 row", row_addr, erow);
    chk("R2 col", col_addr, m_code[5:0]);
    chk("R7 err", short_err, (m_bits < 8));
    tick(1); chk("R9 width", pv(), 4'b0000);
    m_bits = 0;
    tick(2); row_strobe = 1'b1;
    tick(2); chk("R9 early rise", pv(), 4'b0000);
    tick(1); chk(tag, pv(), er);
    chk("R5 row hold", row_addr, erow);
    tick(1); chk("R9 width rise", pv(), 4'b0000);
    tick(2);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R9 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    // R1
    chk("R1 pulses", pv(), 4'b0000);
    chk("R1 row", row_addr, 8'h00);
    chk("R1 col", col_addr, 6'h00);
    chk("R1 err", short_err, 1'b0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 idle", pv(), 4'b0000);

    // R2..R6: exhaustive sweep of the code word
    for (int i = 0; i < 256; i++) begin
      send(8'((i * 37 + 11) & 255), 8'(i), 8);
      xact();
    end

    // R8: eleven bits, last eight kept
    send(8'h3C, 8'h47, 11);
    xact();
    send(8'hA5, 8'h81, 9);
    xact();

    // R7: short loads still latch current contents
    send(8'h5A, 8'h3E, 3);
    xact();
    send(8'h00, 8'h00, 0);
    xact();

    // R6: refresh counter wrap via repeated short refresh strobes
    send(8'h77, 8'hC5, 8);
    xact();
    for (int j = 0; j < 200; j++) xact();
    chk("R6 wrapped", (m_ref < 8'd64), 1'b1);

    finish_run();
  end
endmodule